// File: doc/BRIEF.md
# Display Serial Link Generic Packet Writer

This block is the command-mode front end of a display serial link host controller. Software, or a sequencer standing in for it, queues 32-bit payload words into a payload FIFO and 32-bit header words into a command FIFO. For each header word, in the order the headers were written, the block sends a serial byte stream. The first byte carries the data type and the virtual channel. Two bytes from the header's two-byte field follow. For a long packet, the payload bytes come after those three.

The header word decides how the two-byte field is read. For a long packet the field is the payload byte count. For a short packet it carries up to two inline parameter bytes, and any unused byte is zero. Payload words are packed little-endian, and the block drops the unused upper lanes of a final partial word. Each FIFO has an empty flag that software can poll, and a sticky overflow flag. The byte output is a plain valid/ready stream with an end-of-packet marker. ECC, CRC, lane distribution and the physical layer sit downstream and are not part of this block.

Top module: `dsl_pkt_writer`

## Requirements
- R1: After a synchronous active-low reset, both FIFOs are empty (both empty flags high), both overflow flags are low, and `out_valid` is low.
- R2: Every packet begins with three header bytes taken from the header word. The first is bits [7:0], which hold the data type in [5:0] and the virtual channel (0 to 3) in [7:6]. The second is bits [15:8], the low byte of the two-byte field. The third is bits [23:16], the high byte. Bits [31:24] are ignored.
- R3: A packet is long when the low nibble of its data type is 0x9, 0xB, 0xC, 0xD or 0xE. Every other data type gives a short packet, which consists of exactly the three header bytes, with `out_last` high on the third.
- R4: For a long packet, exactly `{hdr[23:16], hdr[15:8]}` payload bytes follow the header. Within each payload word, bits [7:0] go first, then [15:8], and so on. The unused lanes of the final word are dropped, and that word leaves the FIFO. `out_last` marks the final payload byte, or the third header byte when the count is zero.
- R5: A long packet starts only when the payload FIFO holds at least ceil(count/4) words, or when the payload FIFO is full. If the payload FIFO runs dry partway through a packet, `out_valid` stays low until another word arrives.
- R6: Each empty flag goes low in the cycle after a write is accepted into its FIFO. It stays low until the last entry has been removed.
- R7: Each FIFO holds 16 words. A write to a full FIFO is dropped and sets that FIFO's overflow flag, which stays high until reset. The words already stored are unchanged.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R9: Packets leave in the order their headers were written. A short packet leaves the payload FIFO untouched, so queued payload words stay for the next long packet.
- R10: When the block is idle and the payload condition already holds, the first header byte is valid in the cycle after the header word becomes visible in the command FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pld_wr | input | 1 | Write strobe for the payload FIFO |
| pld_wdata | input | 32 | Payload word, four bytes, little-endian |
| hdr_wr | input | 1 | Write strobe for the command FIFO |
| hdr_wdata | input | 32 | Header word: type [5:0], channel [7:6], field bytes [15:8] and [23:16] |
| out_ready | input | 1 | Downstream accepts a byte |
| out_valid | output | 1 | A byte is on `out_data` |
| out_data | output | 8 | Serial packet byte |
| out_last | output | 1 | Marks the final byte of a packet |
| pld_empty | output | 1 | Payload FIFO empty |
| hdr_empty | output | 1 | Command FIFO empty |
| pld_ovf | output | 1 | Sticky: a payload write was dropped |
| hdr_ovf | output | 1 | Sticky: a header write was dropped |

## Verification
A write sampled at a clock edge shows up on its empty flag right after that edge. From an idle state, the first header byte becomes valid one edge after the command FIFO turns non-empty. The bench drives its inputs and samples the outputs at the falling edge. It checks these two timings at exactly those falling edges. It compares every byte at the falling edge before the rising edge where `valid && ready` completes the transfer. Stream bytes are checked against a queue that bench functions build from the requirements, so random backpressure shifts when each byte is compared but never what is expected.

// File: rtl/dsl_pkt_pkg.sv
// Shared types for the generic packet writer.
// Assumes: header word layout {unused[7:0], field_hi, field_lo, vc[1:0], dt[5:0]}.
package dsl_pkt_pkg;

    localparam int HDR_W = 24;   // header bits kept in the command FIFO
    localparam int WC_W  = 16;   // width of the two-byte field

    typedef struct packed {
        logic [7:0] wc_hi;
        logic [7:0] wc_lo;
        logic [1:0] vc;
        logic [5:0] dt;
    } pkt_hdr_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_B0,
        SQ_B1,
        SQ_B2,
        SQ_PAY
    } sq_state_t;

    // Long packets: data type low nibble 0x9, 0xB, 0xC, 0xD or 0xE.
    function automatic logic dt_is_long(input logic [5:0] dt);
        case (dt[3:0])
            4'h9, 4'hB, 4'hC, 4'hD, 4'hE: return 1'b1;
            default:                      return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dsl_pkt_fifo.sv
// Synchronous single-clock FIFO with a sticky overflow flag.
// Assumes: a write to a full FIFO is dropped even when a pop occurs in the
// same cycle; a read of an empty FIFO is ignored. Storage is not reset.
module dsl_pkt_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          ovf
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    logic          push, pop;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign push    = wr_en && !full;
    assign pop     = rd_en && !empty;
    assign rd_data = mem[rptr];
    assign count   = cnt;

    // Store an accepted word at the write pointer.
    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wr_data;
    end

    // Advance pointers and occupancy; latch overflow on a dropped write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
            ovf  <= 1'b0;
        end else begin
            if (push) wptr <= ptr_next(wptr);
            if (pop)  rptr <= ptr_next(rptr);
            case ({push, pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
            if (wr_en && full) ovf <= 1'b1;
        end
    end

    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    // R7
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> (full && ovf));

    // R6
    empty_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !full && !rd_en) |=> !empty);

endmodule

// File: rtl/dsl_pkt_seq.sv
// Packet sequencer: takes one header from the command FIFO, sends its three
// header bytes, then for long packets the payload bytes from the payload FIFO.
// Assumes: payload words for a long packet were queued before its header;
// one idle cycle separates consecutive packets.
module dsl_pkt_seq
    import dsl_pkt_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hdr_empty,
    input  logic [HDR_W-1:0] hdr_word,
    output logic             hdr_pop,
    input  logic             pld_empty,
    input  logic [CW-1:0]    pld_count,
    input  logic [31:0]      pld_word,
    output logic             pld_pop,
    input  logic             out_ready,
    output logic             out_valid,
    output logic [7:0]       out_data,
    output logic             out_last
);

    localparam int NW = WC_W - 1;   // width of a payload word count

    pkt_hdr_t      in_hdr, hq;
    sq_state_t     st;
    logic          long_q;
    logic [WC_W-1:0] rem;
    logic [1:0]    lane;

    logic [WC_W-1:0] in_wc;
    logic [WC_W:0]   wc_round;
    logic [NW-1:0]   need_words, have_words;
    logic            in_long, pay_ok, start, fire, has_pay;

    // Decode the header at the head of the command FIFO.
    assign in_hdr     = pkt_hdr_t'(hdr_word);
    assign in_wc      = {in_hdr.wc_hi, in_hdr.wc_lo};
    assign wc_round   = {1'b0, in_wc} + (WC_W + 1)'(3);
    assign need_words = wc_round[WC_W:2];
    assign have_words = NW'(pld_count);
    assign in_long    = dt_is_long(in_hdr.dt);
    assign pay_ok     = !in_long || (need_words <= have_words) ||
                        (pld_count == CW'(DEPTH));
    assign start      = (st == SQ_IDLE) && !hdr_empty && pay_ok;
    assign hdr_pop    = start;

    assign has_pay = long_q && ({hq.wc_hi, hq.wc_lo} != '0);
    assign fire    = out_valid && out_ready;
    assign pld_pop = fire && (st == SQ_PAY) && ((lane == 2'd3) || (rem == WC_W'(1)));

    // Drive the output byte, its valid and the end-of-packet marker.
    always_comb begin
        out_valid = 1'b0;
        out_data  = 8'h00;
        out_last  = 1'b0;
        case (st)
            SQ_B0: begin
                out_valid = 1'b1;
                out_data  = {hq.vc, hq.dt};
            end
            SQ_B1: begin
                out_valid = 1'b1;
                out_data  = hq.wc_lo;
            end
            SQ_B2: begin
                out_valid = 1'b1;
                out_data  = hq.wc_hi;
                out_last  = !has_pay;
            end
            SQ_PAY: begin
                out_valid = !pld_empty;
                out_data  = pld_word[{lane, 3'b000} +: 8];
                out_last  = (rem == WC_W'(1));
            end
            default: ;
        endcase
    end

    // Step through header and payload bytes on each accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= SQ_IDLE;
            hq     <= '0;
            long_q <= 1'b0;
            rem    <= '0;
            lane   <= '0;
        end else begin
            case (st)
                SQ_IDLE: if (start) begin
                    hq     <= in_hdr;
                    long_q <= in_long;
                    st     <= SQ_B0;
                end
                SQ_B0: if (fire) st <= SQ_B1;
                SQ_B1: if (fire) st <= SQ_B2;
                SQ_B2: if (fire) begin
                    if (has_pay) begin
                        st   <= SQ_PAY;
                        rem  <= {hq.wc_hi, hq.wc_lo};
                        lane <= 2'd0;
                    end else begin
                        st <= SQ_IDLE;
                    end
                end
                SQ_PAY: if (fire) begin
                    rem  <= rem - WC_W'(1);
                    lane <= lane + 2'd1;
                    if (rem == WC_W'(1)) st <= SQ_IDLE;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R4
    last_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid);

    // R10
    pop_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_pop |=> out_valid);

endmodule

// File: rtl/dsl_pkt_writer.sv
// Top of the generic packet writer: a payload FIFO, a command FIFO and the
// packet sequencer that serialises them into a valid/ready byte stream.
// Assumes: one clock domain; header bits [31:24] carry no meaning.
module dsl_pkt_writer
    import dsl_pkt_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pld_wr,
    input  logic [31:0] pld_wdata,
    input  logic        hdr_wr,
    input  logic [31:0] hdr_wdata,
    input  logic        out_ready,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic        out_last,
    output logic        pld_empty,
    output logic        hdr_empty,
    output logic        pld_ovf,
    output logic        hdr_ovf
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [31:0]      pld_head;
    logic [CW-1:0]    pld_cnt;
    logic             pld_pop;
    logic             pld_full_unused;
    logic [HDR_W-1:0] hdr_head;
    logic [CW-1:0]    hdr_cnt_unused;
    logic             hdr_full_unused;
    logic             hdr_pop;
    logic [7:0]       hdr_top_unused;

    assign hdr_top_unused = hdr_wdata[31:24];

    dsl_pkt_fifo #(.W(32), .DEPTH(DEPTH), .CW(CW)) u_pld_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pld_wr),
        .wr_data (pld_wdata),
        .rd_en   (pld_pop),
        .rd_data (pld_head),
        .count   (pld_cnt),
        .empty   (pld_empty),
        .full    (pld_full_unused),
        .ovf     (pld_ovf)
    );

    dsl_pkt_fifo #(.W(HDR_W), .DEPTH(DEPTH), .CW(CW)) u_hdr_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (hdr_wr),
        .wr_data (hdr_wdata[HDR_W-1:0]),
        .rd_en   (hdr_pop),
        .rd_data (hdr_head),
        .count   (hdr_cnt_unused),
        .empty   (hdr_empty),
        .full    (hdr_full_unused),
        .ovf     (hdr_ovf)
    );

    dsl_pkt_seq #(.DEPTH(DEPTH), .CW(CW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_empty (hdr_empty),
        .hdr_word  (hdr_head),
        .hdr_pop   (hdr_pop),
        .pld_empty (pld_empty),
        .pld_count (pld_cnt),
        .pld_word  (pld_head),
        .pld_pop   (pld_pop),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last)
    );

endmodule

// File: tb/tb_dsl_pkt_writer.sv
module tb_dsl_pkt_writer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pld_wr = 1'b0, hdr_wr = 1'b0, out_ready = 1'b0;
    logic [31:0] pld_wdata = '0, hdr_wdata = '0;
    logic        out_valid, out_last, pld_empty, hdr_empty, pld_ovf, hdr_ovf;
    logic [7:0]  out_data;

    always #5 clk = ~clk;

    dsl_pkt_writer dut (
        .clk(clk), .rst_n(rst_n), .pld_wr(pld_wr), .pld_wdata(pld_wdata),
        .hdr_wr(hdr_wr), .hdr_wdata(hdr_wdata), .out_ready(out_ready),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .pld_empty(pld_empty), .hdr_empty(hdr_empty),
        .pld_ovf(pld_ovf), .hdr_ovf(hdr_ovf)
    );

    typedef struct { logic [7:0] d; logic l; string r; } exp_t;
    exp_t        expq[$];
    logic [31:0] late_q[$];
    int          checks = 0, errors = 0;
    int          rdy_mode = 0;
    logic        p_pld = 0, p_hdr = 0, p_rst = 0;
    logic [31:0] p_pd = '0, p_hd = '0;
    logic        hold_pend = 0;
    logic [7:0]  hold_d;
    logic        hold_l;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_long(input logic [5:0] dt);
        return (dt[3:0] == 4'h9) || (dt[3:0] >= 4'hB && dt[3:0] <= 4'hE);
    endfunction

    function automatic void exp_push(input logic [7:0] d, input logic l, input string r);
        exp_t e;
        e.d = d; e.l = l; e.r = r;
        expq.push_back(e);
    endfunction

    // One cycle: apply inputs at the falling edge, then compare the stream.
    task automatic tick();
        exp_t e;
        @(negedge clk);
        rst_n     = p_rst;
        pld_wr    = p_pld; pld_wdata = p_pd;
        hdr_wr    = p_hdr; hdr_wdata = p_hd;
        out_ready = (rdy_mode == 2) ? 1'($urandom % 2) : (rdy_mode == 1);
        if (hold_pend) begin
            chk(out_valid === 1'b1 && out_data === hold_d && out_last === hold_l,
                "R8", "held byte", {23'd0, out_valid, out_data}, {23'd1, 1'b1, hold_d});
            hold_pend = 0;
        end
        if (rst_n && out_valid === 1'b1 && !out_ready) begin
            hold_pend = 1; hold_d = out_data; hold_l = out_last;
        end
        if (rst_n && out_valid === 1'b1 && out_ready) begin
            if (expq.size() == 0) begin
                chk(0, "R9", "unexpected byte", {24'd0, out_data}, 32'd0);
            end else begin
                e = expq.pop_front();
                chk(out_data === e.d, e.r, "byte", {24'd0, out_data}, {24'd0, e.d});
                chk(out_last === e.l, e.r, "last flag", {31'd0, out_last}, {31'd0, e.l});
            end
        end
    endtask

    task automatic push_pld(input logic [31:0] w);
        p_pld = 1; p_pd = w; tick(); p_pld = 0;
    endtask

    task automatic push_hdr(input logic [31:0] w);
        p_hdr = 1; p_hd = w; tick(); p_hdr = 0;
    endtask

    task automatic push_late();
        while (late_q.size() != 0) push_pld(late_q.pop_front());
    endtask

    task automatic do_reset();
        rdy_mode = 0; p_rst = 0;
        repeat (3) tick();
        p_rst = 1;
        tick();
        expq.delete(); late_q.delete(); hold_pend = 0;
    endtask

    task automatic drain(input string req);
        int g = 0;
        while (expq.size() != 0 && g < 3000) begin tick(); g++; end
        chk(expq.size() == 0, req, "bytes left after drain", expq.size(), 0);
        tick();
        chk(out_valid == 1'b0, req, "valid after drain", {31'd0, out_valid}, 0);
    endtask

    task automatic wait_empty();
        int g = 0;
        while (!(pld_empty && hdr_empty) && g < 3000) begin tick(); g++; end
    endtask

    task automatic send_short(input logic [5:0] dt, input logic [1:0] vc,
                              input logic [7:0] b0, input logic [7:0] b1);
        exp_push({vc, dt}, 0, "R3");
        exp_push(b0, 0, "R3");
        exp_push(b1, 1, "R3");
        push_hdr({8'h00, b1, b0, vc, dt});
    endtask

    // Long packet: `split` words go in before the header, the rest wait in late_q.
    task automatic send_long(input logic [5:0] dt, input logic [1:0] vc,
                             input int wc, input int split);
        logic [7:0]  by[$];
        logic [15:0] wcv;
        logic [31:0] word;
        int          nw;
        wcv = 16'(wc);
        for (int i = 0; i < wc; i++) by.push_back(8'($urandom));
        exp_push({vc, dt}, 0, "R2");
        exp_push(wcv[7:0], 0, "R2");
        exp_push(wcv[15:8], wc == 0, "R2");
        for (int i = 0; i < wc; i++) exp_push(by[i], i == wc - 1, "R4");
        nw = (wc + 3) / 4;
        for (int w = 0; w < nw; w++) begin
            word = $urandom;
            for (int k = 0; k < 4; k++)
                if (w * 4 + k < wc) word[k*8 +: 8] = by[w * 4 + k];
            if (w < split) push_pld(word);
            else           late_q.push_back(word);
        end
        push_hdr({8'hEE, wcv[15:8], wcv[7:0], vc, dt});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [5:0] dt;
        logic [7:0] b0, b1;
        int         n;
        void'($urandom(32'd20240611));

        // R1: reset state
        do_reset();
        chk(pld_empty && hdr_empty, "R1", "empty flags", {30'd0, pld_empty, hdr_empty}, 3);
        chk(!pld_ovf && !hdr_ovf, "R1", "ovf flags", {30'd0, pld_ovf, hdr_ovf}, 0);
        chk(out_valid == 0, "R1", "out_valid", {31'd0, out_valid}, 0);

        // R10 / R6: latency of the first byte after a header write
        rdy_mode = 1;
        send_short(6'h05, 2'd1, 8'h3C, 8'h00);
        tick();
        chk(hdr_empty == 0 && out_valid == 0, "R6", "header visible, no byte yet",
            {30'd0, hdr_empty, out_valid}, 0);
        tick();
        chk(out_valid == 1, "R10", "first byte one cycle later", {31'd0, out_valid}, 1);
        drain("R3");

        // R4: zero-length long packet is header only
        send_long(6'h39, 2'd2, 0, 1000);
        drain("R4");

        // R4: odd count, unused lanes dropped, next packet unaffected
        send_long(6'h29, 2'd1, 5, 1000);
        send_short(6'h15, 2'd3, 8'hA1, 8'h00);
        drain("R4");
        chk(pld_empty == 1, "R4", "final partial word removed", {31'd0, pld_empty}, 1);

        // R9: short packet leaves queued payload alone
        push_pld(32'h44332211);
        tick();
        chk(pld_empty == 0, "R6", "payload visible", {31'd0, pld_empty}, 0);
        send_short(6'h23, 2'd0, 8'h10, 8'h20);
        drain("R9");
        chk(pld_empty == 0, "R9", "payload kept by short packet", {31'd0, pld_empty}, 0);
        exp_push(8'h29, 0, "R9"); exp_push(8'h04, 0, "R9"); exp_push(8'h00, 0, "R9");
        exp_push(8'h11, 0, "R9"); exp_push(8'h22, 0, "R9");
        exp_push(8'h33, 0, "R9"); exp_push(8'h44, 1, "R9");
        push_hdr(32'h00000429);
        drain("R9");

        // R5: long packet waits for enough payload
        send_long(6'h29, 2'd0, 8, 1);
        repeat (8) tick();
        chk(out_valid == 0 && hdr_empty == 0, "R5", "waits for payload",
            {30'd0, out_valid, hdr_empty}, 0);
        chk(expq.size() == 11, "R5", "nothing sent early", expq.size(), 11);
        push_late();
        drain("R5");

        // R5: count beyond the FIFO starts when full, stalls mid-packet
        wait_empty();
        send_long(6'h39, 2'd3, 68, 16);
        repeat (75) tick();
        chk(out_valid == 0, "R5", "stall when payload runs dry", {31'd0, out_valid}, 0);
        chk(expq.size() == 4, "R5", "bytes pending at stall", expq.size(), 4);
        push_late();
        drain("R5");

        // Random packets under random backpressure (R2, R3, R4, R8, R9)
        rdy_mode = 2;
        for (int p = 0; p < 150; p++) begin
            wait_empty();
            if ($urandom % 2) begin
                do dt = 6'($urandom); while (!is_long(dt));
                send_long(dt, 2'($urandom), int'($urandom % 65), 1000);
            end else begin
                do dt = 6'($urandom); while (is_long(dt));
                n  = int'($urandom % 3);
                b0 = (n > 0) ? 8'($urandom) : 8'h00;
                b1 = (n > 1) ? 8'($urandom) : 8'h00;
                send_short(dt, 2'($urandom), b0, b1);
            end
        end
        drain("R9");

        // R7: payload overflow drops the seventeenth word
        do_reset();
        for (int i = 0; i < 17; i++) push_pld(32'hA5000000 | i);
        tick();
        chk(pld_ovf == 1 && hdr_ovf == 0, "R7", "payload overflow flag",
            {30'd0, pld_ovf, hdr_ovf}, 2);
        exp_push(8'h39, 0, "R7"); exp_push(8'h40, 0, "R7"); exp_push(8'h00, 0, "R7");
        for (int i = 0; i < 16; i++) begin
            exp_push(8'(i), 0, "R7"); exp_push(8'h00, 0, "R7");
            exp_push(8'h00, 0, "R7"); exp_push(8'hA5, i == 15, "R7");
        end
        push_hdr(32'h00004039);
        rdy_mode = 1;
        drain("R7");
        chk(pld_empty == 1, "R7", "dropped word not stored", {31'd0, pld_empty}, 1);
        chk(pld_ovf == 1, "R7", "overflow sticky", {31'd0, pld_ovf}, 1);

        // R7: command FIFO overflow (one header already taken by the sequencer)
        rdy_mode = 0;
        for (int i = 0; i < 18; i++) begin
            if (i < 17) begin
                exp_push(8'h03, 0, "R7"); exp_push(8'(i), 0, "R7"); exp_push(8'h00, 1, "R7");
            end
            push_hdr({16'h0000, 8'(i), 8'h03});
        end
        tick();
        chk(hdr_ovf == 1, "R7", "header overflow flag", {31'd0, hdr_ovf}, 1);
        rdy_mode = 1;
        drain("R7");

        // R7 / R1: reset clears the sticky flags
        do_reset();
        chk(!pld_ovf && !hdr_ovf && pld_empty && hdr_empty, "R7", "flags after reset",
            {28'd0, pld_ovf, hdr_ovf, pld_empty, hdr_empty}, 3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule